// File: doc/BRIEF.md
# I2C Register Slave with Attention Output

This block is an I2C slave that gives a host processor access to a small bank of 8-bit registers. Every register except the last is a read/write control register. Each one appears on a parallel output bus, and a one-cycle strobe marks each write. The last register holds status. It is read-only and collects sticky bits from a status input port. The device address has seven bits: the upper five come from a parameter and the lower two come from a strap input, so four devices can share one bus.

A transaction starts with the device address and the direction bit. A write sends a register pointer byte next, followed by any number of data bytes. A read sets the pointer with a short write, then issues a repeated START and the address with the read bit set. The pointer advances after every data byte in either direction and wraps from the last register to 0. An active-low attention output tells the host that new status bits have been latched. It clears without any further action once the host fetches the status register. While the undervoltage-lockout input is high the slave acknowledges nothing.

SCL and SDA are sampled into the system clock domain. The slave pulls SDA low through an open-drain enable.

Top module: `i2c_attn_slave`

## Requirements
- R1: The slave acknowledges a first byte only when its upper seven bits equal `{ADDR_BASE[6:2], strap}` (default base 7'h30, so strap 1 gives 7'h31). It does not acknowledge any other address, and the rest of that transaction has no effect.
- R2: In a write, the byte after the address sets the register pointer (its low bits). Each following data byte is stored in register `ptr`, whose value appears on `ctrl_out[8*ptr +: 8]`. Each stored byte produces exactly one one-cycle pulse on `wr_stb[ptr]`.
- R3: The pointer advances by one after every data byte and wraps from register NREG-1 to register 0.
- R4: A read uses this sequence: write the pointer, repeated START, then the address with bit 0 set to 1. The slave then returns consecutive registers, MSB first. SDA changes only while SCL is low.
- R5: The status register sits at index NREG-1 (3 by default). A read returns the OR of every `stat_in` value seen since that register was last read. A write to this index is acknowledged, stores nothing and still advances the pointer.
- R6: `attn_n` goes low when a `stat_in` bit that is enabled by ATTN_MASK is newly set in the status latch. It stays low until the status register is loaded for transmission to the host, and then returns high.
- R7: While `uvlo` is high the slave acknowledges no byte, whether address, pointer or data. A data byte that is refused is not stored.
- R8: After the master answers a read byte with NACK, the slave releases SDA and keeps it released until the next START or STOP. A later transaction then works normally.
- R9: After reset every control register is 0, `attn_n` is high and `sda_oe` is 0.
- R10: A START seen part-way through a byte discards the partial byte and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level, asynchronous |
| sda_in | input | 1 | SDA line level, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| strap | input | 2 | Low two bits of the device address |
| uvlo | input | 1 | Undervoltage lockout; 1 suppresses every acknowledge |
| stat_in | input | 8 | Status event bits, OR-ed into the status latch |
| attn_n | output | 1 | Active-low attention |
| ctrl_out | output | 8*(NREG-1) | Control registers; register i in bits [8i+7:8i] |
| wr_stb | output | NREG-1 | One-cycle write pulse per control register |

## Verification
The assertions check four things on every cycle. The write strobes are one-hot and last a single cycle. SDA never changes while SCL is high. An acknowledge is never driven when lockout was active at the decision cycle. Attention, once asserted, cannot rise again without a status-register fetch. The bench's bus scenarios are needed to show the behaviours that depend on data values. These are address matching against the strap, pointer wrap in both directions, the content of a burst read, the silent drop of a status write, the release of SDA after a NACK and recovery from a START in the middle of a byte.

// File: rtl/i2c_attn_slave.sv
module i2c_attn_slave #(
  parameter int         NREG      = 4,
  parameter logic [6:0] ADDR_BASE = 7'h30,
  parameter logic [7:0] ATTN_MASK = 8'hFF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_in,
  input  logic                    sda_in,
  output logic                    sda_oe,
  input  logic [1:0]              strap,
  input  logic                    uvlo,
  input  logic [7:0]              stat_in,
  output logic                    attn_n,
  output logic [8*(NREG-1)-1:0]   ctrl_out,
  output logic [NREG-2:0]         wr_stb
);
  localparam int NCTL = NREG - 1;
  localparam int PW   = $clog2(NREG);
  localparam logic [PW-1:0] STAT_IDX = PW'(NREG - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_REG, S_WDAT, S_ACK, S_RDAT, S_RACK} st_t;

  logic [2:0] scl_p, sda_p;
  logic       scl_s, sda_s, scl_q, sda_q;
  logic       start, stop, scl_rise, scl_fall;
  st_t        state, nxt;
  logic [3:0] bitcnt;
  logic [7:0] sh;
  logic [6:0] tx;
  logic       mack;
  logic [PW-1:0] ptr;
  logic [8*NCTL-1:0] ctrl_q;
  logic [7:0] stat_q, rd_val;
  logic       load_rd, stat_clr, rd_phase;
  logic [6:0] dev_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end

  assign scl_s    = scl_p[1];
  assign sda_s    = sda_p[1];
  assign scl_q    = scl_p[2];
  assign sda_q    = sda_p[2];
  assign start    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop     = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign dev_addr = {ADDR_BASE[6:2], strap};
  assign rd_val   = (ptr == STAT_IDX) ? stat_q : ctrl_q[ptr*8 +: 8];
  assign ctrl_out = ctrl_q;
  assign rd_phase = (state == S_RDAT);

  assign load_rd  = !start && !stop && scl_fall &&
                    ((state == S_ACK && nxt == S_RDAT) || (state == S_RACK && mack));
  assign stat_clr = load_rd && (ptr == STAT_IDX);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= S_IDLE;
      nxt    <= S_IDLE;
      bitcnt <= '0;
      sh     <= '0;
      tx     <= '0;
      mack   <= 1'b0;
      ptr    <= '0;
      ctrl_q <= '0;
      sda_oe <= 1'b0;
      wr_stb <= '0;
    end else begin
      wr_stb <= '0;
      if (start) begin
        state  <= S_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_REG, S_WDAT:
            if (scl_rise && bitcnt != 4'd8) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (uvlo || (state == S_ADDR && sh[7:1] != dev_addr)) begin
                state <= S_IDLE;
              end else begin
                sda_oe <= 1'b1;
                state  <= S_ACK;
                if (state == S_ADDR) begin
                  nxt <= sh[0] ? S_RDAT : S_REG;
                end else if (state == S_REG) begin
                  ptr <= sh[PW-1:0];
                  nxt <= S_WDAT;
                end else begin
                  if (ptr != STAT_IDX) begin
                    ctrl_q[ptr*8 +: 8] <= sh;
                    wr_stb <= {{(NCTL-1){1'b0}}, 1'b1} << ptr;
                  end
                  ptr <= ptr + PW'(1);
                  nxt <= S_WDAT;
                end
              end
            end
          S_ACK:
            if (scl_fall) begin
              bitcnt <= '0;
              state  <= nxt;
              if (nxt == S_RDAT) begin
                tx     <= rd_val[6:0];
                sda_oe <= ~rd_val[7];
                ptr    <= ptr + PW'(1);
                mack   <= 1'b0;
              end else begin
                sda_oe <= 1'b0;
              end
            end
          S_RDAT:
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= S_RACK;
              end else begin
                sda_oe <= ~tx[6];
                tx     <= {tx[5:0], 1'b0};
              end
            end
          S_RACK:
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                tx     <= rd_val[6:0];
                sda_oe <= ~rd_val[7];
                ptr    <= ptr + PW'(1);
                bitcnt <= '0;
                mack   <= 1'b0;
                state  <= S_RDAT;
              end else begin
                state <= S_IDLE;
              end
            end
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stat_q <= '0;
      attn_n <= 1'b1;
    end else begin
      stat_q <= (stat_clr ? 8'h00 : stat_q) | stat_in;
      if (|(stat_in & ~stat_q & ATTN_MASK))
        attn_n <= 1'b0;
      else if (stat_clr)
        attn_n <= 1'b1;
    end
endmodule

// File: rtl/i2c_attn_slave_chk.sv
module i2c_attn_slave_chk #(
  parameter int W = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         scl_s,
  input logic         sda_oe,
  input logic         uvlo,
  input logic         rd_phase,
  input logic         stat_clr,
  input logic         attn_n,
  input logic [W-1:0] wr_stb
);
  p_stb_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));

  p_stb_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_stb) |=> !(|wr_stb));

  p_sda_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  p_no_ack_uvlo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && !rd_phase) |-> !$past(uvlo));

  p_attn_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!attn_n && !stat_clr) |=> !attn_n);
endmodule

bind i2c_attn_slave i2c_attn_slave_chk #(.W(NREG-1)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .uvlo(uvlo),
  .rd_phase(rd_phase), .stat_clr(stat_clr), .attn_n(attn_n), .wr_stb(wr_stb)
);

// File: tb/sim_i2c_attn_slave.sv
module sim_i2c_attn_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam logic [6:0] BASE = 7'h30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'd1;
  logic uvlo = 1'b0;
  logic [7:0] stat_in = 8'h00;
  logic sda_oe, attn_n;
  logic [23:0] ctrl_out;
  logic [2:0] wr_stb;
  wire sda_line = sda_m & ~sda_oe;

  int errors = 0, checks = 0;
  int stb_cnt [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_attn_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
    .strap(strap), .uvlo(uvlo), .stat_in(stat_in), .attn_n(attn_n),
    .ctrl_out(ctrl_out), .wr_stb(wr_stb)
  );

  always @(posedge clk)
    for (int i = 0; i < 3; i++) if (wr_stb[i]) stb_cnt[i]++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic rd_byte(input logic nack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(nack);
  endtask

  function automatic logic [7:0] aw();
    return {BASE[6:2], strap, 1'b0};
  endfunction

  task automatic set_ptr_read(input logic [7:0] p, output logic ok);
    logic a1, a2, a3;
    bus_start(); wr_byte(aw(), a1); wr_byte(p, a2);
    bus_start(); wr_byte(aw() | 8'h01, a3);
    ok = a1 & a2 & a3;
  endtask

  task automatic t_reset();
    chk(ctrl_out == 24'h0, "R9 ctrl after reset", ctrl_out, 0);
    chk(attn_n == 1'b1, "R9 attn_n after reset", attn_n, 1);
    chk(sda_oe == 1'b0, "R9 sda_oe after reset", sda_oe, 0);
  endtask

  task automatic t_addr_strap();
    logic a;
    strap = 2'd1;
    bus_start(); wr_byte(8'h62, a); bus_stop();
    chk(a == 1'b1, "R1 ack on 0x31 with strap 1", a, 1);
    bus_start(); wr_byte(8'h64, a); wr_byte(8'h00, a); wr_byte(8'hEE, a); bus_stop();
    chk(a == 1'b0 && ctrl_out == 24'h0, "R1 no ack/no write on 0x32 with strap 1", ctrl_out, 0);
    strap = 2'd2;
  endtask

  task automatic t_write_wrap();
    logic a1, a2, a3, a4, a5, a6;
    for (int i = 0; i < 3; i++) stb_cnt[i] = 0;
    bus_start(); wr_byte(aw(), a1); wr_byte(8'h01, a2);
    wr_byte(8'hA1, a3); wr_byte(8'hB2, a4); wr_byte(8'hC3, a5); wr_byte(8'hD4, a6);
    bus_stop();
    chk(a1 & a2 & a3 & a4 & a5 & a6, "R5 every byte acked incl. status slot", {a1,a2,a3,a4,a5,a6}, 6'h3F);
    chk(ctrl_out[15:8] == 8'hA1 && ctrl_out[23:16] == 8'hB2, "R2 regs 1,2 written", ctrl_out, 24'hB2A100);
    chk(ctrl_out[7:0] == 8'hD4, "R3 pointer wrapped to reg 0", ctrl_out[7:0], 8'hD4);
    chk(stb_cnt[0] == 1 && stb_cnt[1] == 1 && stb_cnt[2] == 1, "R2 one strobe per stored byte",
        {stb_cnt[2][7:0], stb_cnt[1][7:0], stb_cnt[0][7:0]}, 24'h010101);
  endtask

  task automatic t_read_burst();
    logic ok;
    logic [7:0] d [5];
    set_ptr_read(8'h00, ok);
    for (int i = 0; i < 5; i++) rd_byte(i == 4, d[i]);
    bus_stop();
    chk(ok, "R4 read setup acked", ok, 1);
    chk({d[0], d[1], d[2]} == 24'hD4A1B2, "R4 burst read regs 0..2", {d[0], d[1], d[2]}, 24'hD4A1B2);
    chk(d[3] == 8'h00, "R5 status write was ignored", d[3], 8'h00);
    chk(d[4] == 8'hD4, "R3 read pointer wraps to 0", d[4], 8'hD4);
  endtask

  task automatic t_status_attn();
    logic ok;
    logic [7:0] d;
    stat_in = 8'h04; @(negedge clk); stat_in = 8'h01; @(negedge clk); stat_in = 8'h00;
    repeat (3) @(negedge clk);
    chk(attn_n == 1'b0, "R6 attn_n low after new status", attn_n, 0);
    set_ptr_read(8'h02, ok); rd_byte(1'b1, d); bus_stop();
    chk(d == 8'hB2 && attn_n == 1'b0, "R6 attn_n held over non-status read", {d, 7'h0, attn_n}, 16'hB200);
    set_ptr_read(8'h03, ok); rd_byte(1'b1, d); bus_stop();
    chk(d == 8'h05, "R5 status holds OR of events", d, 8'h05);
    chk(attn_n == 1'b1, "R6 attn_n released after status read", attn_n, 1);
    set_ptr_read(8'h03, ok); rd_byte(1'b1, d); bus_stop();
    chk(d == 8'h00, "R5 status cleared by read", d, 8'h00);
  endtask

  task automatic t_uvlo();
    logic a1, a2, a3;
    uvlo = 1'b1;
    bus_start(); wr_byte(aw(), a1); bus_stop();
    chk(a1 == 1'b0, "R7 no address ack in lockout", a1, 0);
    uvlo = 1'b0;
    bus_start(); wr_byte(aw(), a1); wr_byte(8'h00, a2);
    uvlo = 1'b1;
    wr_byte(8'h77, a3); bus_stop();
    uvlo = 1'b0;
    chk(a1 & a2 & ~a3, "R7 data byte refused in lockout", {a1, a2, a3}, 3'b110);
    chk(ctrl_out[7:0] == 8'hD4, "R7 refused byte not stored", ctrl_out[7:0], 8'hD4);
  endtask

  task automatic t_nack_release();
    logic ok, b;
    logic [7:0] d;
    set_ptr_read(8'h01, ok); rd_byte(1'b1, d);
    chk(d == 8'hA1, "R8 single read before NACK", d, 8'hA1);
    bit_in(b);
    chk(b == 1'b1 && sda_oe == 1'b0, "R8 SDA released after NACK", {b, sda_oe}, 2'b10);
    bus_stop();
    set_ptr_read(8'h02, ok); rd_byte(1'b1, d); bus_stop();
    chk(ok && d == 8'hB2, "R8 next transaction after NACK", d, 8'hB2);
  endtask

  task automatic t_midbyte_start();
    logic a1, a2, a3;
    bus_start(); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
    bus_start(); wr_byte(aw(), a1); wr_byte(8'h00, a2); wr_byte(8'h5A, a3); bus_stop();
    chk(a1 & a2 & a3, "R10 address after mid-byte START acked", {a1, a2, a3}, 3'b111);
    chk(ctrl_out[7:0] == 8'h5A, "R10 write after mid-byte START", ctrl_out[7:0], 8'h5A);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_addr_strap();
    t_write_wrap();
    t_read_burst();
    t_status_attn();
    t_uvlo();
    t_nack_release();
    t_midbyte_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule